// File: doc/BRIEF.md
# Threshold-Gated Sensor Logger

This block takes one sensor sample at a time and keeps it only when it is large enough. A sample arrives with a valid strobe and is caught in a sample register. A comparator then tests it against a threshold register. If the test passes, the sample is written into a small on-chip memory at the current log address, and the log address then moves on by one. If the test fails, the step ends and nothing is stored.

Each unit in the chain has its own power-enable bit in a control word that an external sequencer drives. Each unit starts the next one with a one-cycle done pulse, so a unit that is switched off breaks the chain at that point. The stored samples can be read back through a registered read port. When the log address passes the last memory location it returns to zero, and a sticky flag records this.

Top module: `thresh_logger`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `hit`, `miss`, `done` and `wrapped`, and sets `log_addr` to 0.
- R2: A sample is taken when `smp_valid` is high and power bit 0 is set at clock edge k. Its outcome appears on `hit` or `miss` as a single-cycle pulse after edge k+1.
- R3: The comparison is unsigned. It reports `hit` when sample >= threshold and `miss` otherwise, and the two are never high together.
- R4: On a hit, and with power bit 3 set, the sample is written at edge k+2 to memory location `log_addr`. Setting `rd_addr` before an edge gives that location on `rd_data` after the edge, while bit 3 is set.
- R5: After a written hit, with power bit 4 set, `log_addr` advances by one at edge k+3. A miss leaves `log_addr` unchanged.
- R6: An advance from address DEPTH-1 goes to 0 and sets `wrapped`. `wrapped` stays set until reset.
- R7: `done` is a single-cycle pulse, once per completed sample. It comes after edge k+2 on a miss and after edge k+4 on a hit.
- R8: The threshold register loads `thr_value` only when `thr_load` is high and power bit 1 is set. Otherwise the old threshold stays in use.
- R9: When a unit's power bit is clear, that unit does nothing and issues no done. Bit 0 is the sample register, bit 2 the comparator, bit 3 the memory and bit 4 the address unit. Nothing later in the chain acts: no outcome, no write, no address change and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 5 | Per-unit power enables (bit0 sample, bit1 threshold, bit2 comparator, bit3 memory, bit4 address) |
| thr_load | input | 1 | Threshold load strobe |
| thr_value | input | DATA_W | New threshold value |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_data | input | DATA_W | Sample value |
| rd_addr | input | ADDR_W | Read-back address |
| rd_data | output | DATA_W | Read-back data, one cycle after address |
| hit | output | 1 | Comparison true pulse |
| miss | output | 1 | Comparison false pulse |
| done | output | 1 | Overall completion pulse |
| log_addr | output | ADDR_W | Current log address |
| wrapped | output | 1 | Sticky address wrap flag |

## Verification
Let edge k be the edge that captures the sample. The outcome is due one edge later, at k+1. The memory write happens at k+2 and the address step at k+3. `done` comes after k+2 for a miss and after k+4 for a hit. The bench drives each sample on a falling edge and then walks one falling edge at a time. At every step it compares `hit`, `miss`, `done`, `log_addr` and `wrapped` with the value due for that exact interval, including the intervals where each pulse must already be low. Read-back is checked one edge after the address is applied. The tests with a unit switched off watch all outputs for five cycles.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int PW_SMP = 0;
  localparam int PW_THR = 1;
  localparam int PW_CMP = 2;
  localparam int PW_MEM = 3;
  localparam int PW_ADR = 4;
  localparam int PW_W   = 5;
  typedef logic [PW_W-1:0] pwr_t;
endpackage

// File: rtl/tl_sample_reg.sv
module tl_sample_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr,
  input  logic              valid,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (pwr && valid) begin
        q    <= din;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tl_compare.sv
module tl_compare #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_thr,
  input  logic              pwr_cmp,
  input  logic              thr_load,
  input  logic [DATA_W-1:0] thr_din,
  input  logic              start,
  input  logic [DATA_W-1:0] sample,
  output logic              is_true,
  output logic              is_false
);
  logic [DATA_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (rst) thr_q <= '0;
    else if (pwr_thr && thr_load) thr_q <= thr_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_true  <= 1'b0;
      is_false <= 1'b0;
    end else begin
      is_true  <= 1'b0;
      is_false <= 1'b0;
      if (pwr_cmp && start) begin
        if (sample >= thr_q) is_true  <= 1'b1;
        else                 is_false <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tl_sram.sv
module tl_sram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              wdone
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pwr && we) mem[waddr] <= wdata;
    if (pwr) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) wdone <= 1'b0;
    else     wdone <= pwr && we;
  end
endmodule

// File: rtl/tl_addr_gen.sv
module tl_addr_gen #(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      wrap <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (pwr && step) begin
        done <= 1'b1;
        if (addr == LAST) begin
          addr <= '0;
          wrap <= 1'b1;
        end else begin
          addr <= addr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/thresh_logger.sv
module thresh_logger
  import tl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW_W-1:0]   pwr_en,
  input  logic              thr_load,
  input  logic [DATA_W-1:0] thr_value,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hit,
  output logic              miss,
  output logic              done,
  output logic [ADDR_W-1:0] log_addr,
  output logic              wrapped
);
  logic [DATA_W-1:0] smp_q;
  logic              smp_done;
  logic              mem_done;
  logic              adr_done;

  tl_sample_reg #(.DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst(rst), .pwr(pwr_en[PW_SMP]), .valid(smp_valid),
    .din(smp_data), .q(smp_q), .done(smp_done)
  );

  tl_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .pwr_thr(pwr_en[PW_THR]), .pwr_cmp(pwr_en[PW_CMP]),
    .thr_load(thr_load), .thr_din(thr_value), .start(smp_done),
    .sample(smp_q), .is_true(hit), .is_false(miss)
  );

  tl_sram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst), .pwr(pwr_en[PW_MEM]), .we(hit), .waddr(log_addr),
    .wdata(smp_q), .raddr(rd_addr), .rdata(rd_data), .wdone(mem_done)
  );

  tl_addr_gen #(.DEPTH(DEPTH)) u_adr (
    .clk(clk), .rst(rst), .pwr(pwr_en[PW_ADR]), .step(mem_done),
    .addr(log_addr), .wrap(wrapped), .done(adr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= miss | adr_done;
  end
endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              hit,
  input logic              miss,
  input logic              done,
  input logic              wrapped,
  input logic [ADDR_W-1:0] log_addr,
  input logic              smp_done,
  input logic              mem_done
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss));

  p_outcome_follows_sample_r2: assert property (@(posedge clk) disable iff (rst)
    (hit || miss) |-> $past(smp_done));

  p_write_needs_hit_r4: assert property (@(posedge clk) disable iff (rst)
    mem_done |-> $past(hit));

  p_addr_steps_by_one_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && log_addr != $past(log_addr)) |->
      (log_addr == (($past(log_addr) == LAST) ? '0 : $past(log_addr) + 1'b1)));

  p_miss_keeps_addr_r5: assert property (@(posedge clk) disable iff (rst)
    miss |=> $stable(log_addr));

  p_wrap_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    wrapped |=> wrapped);

  p_wrap_lands_zero_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wrapped) |-> log_addr == '0);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind thresh_logger tl_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .hit(hit), .miss(miss), .done(done),
  .wrapped(wrapped), .log_addr(log_addr), .smp_done(smp_done),
  .mem_done(mem_done)
);

// File: tb/sim_thresh_logger.sv
module sim_thresh_logger;
  import tl_pkg::*;
  localparam int DW = 8;
  localparam int DP = 16;
  localparam int AW = $clog2(DP);
  localparam int NV = 8;
  // {threshold, sample, expected hit}
  localparam logic [2*DW:0] VEC [NV] = '{
    {8'h80, 8'h80, 1'b1}, {8'h80, 8'h7F, 1'b0}, {8'h00, 8'h00, 1'b1},
    {8'hFF, 8'hFE, 1'b0}, {8'hFF, 8'hFF, 1'b1}, {8'h10, 8'hF0, 1'b1},
    {8'hF0, 8'h10, 1'b0}, {8'h01, 8'h00, 1'b0}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW_W-1:0] pwr_en = '1;
  logic thr_load = 1'b0;
  logic [DW-1:0] thr_value = '0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic hit, miss, done, wrapped;
  logic [AW-1:0] log_addr;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] exp_mem [DP];
  int exp_addr = 0;
  bit exp_wrap = 1'b0;

  always #4 clk = ~clk;

  thresh_logger #(.DATA_W(DW), .DEPTH(DP)) u0 (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .thr_load(thr_load),
    .thr_value(thr_value), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hit(hit), .miss(miss),
    .done(done), .log_addr(log_addr), .wrapped(wrapped));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic set_thr(input logic [DW-1:0] v);
    @(negedge clk); thr_value = v; thr_load = 1'b1;
    @(negedge clk); thr_load = 1'b0;
  endtask

  task automatic log_one(input logic [DW-1:0] s, input bit exp_hit);
    bit wr;
    bit st;
    wr = exp_hit && pwr_en[PW_MEM];
    st = wr && pwr_en[PW_ADR];
    @(negedge clk); smp_valid = 1'b1; smp_data = s;
    @(negedge clk); smp_valid = 1'b0;                 // after edge k
    chk(!hit && !miss, "R2", hit | miss, 0);
    @(negedge clk);                                   // after k+1
    chk(hit == exp_hit, "R3", hit, exp_hit);
    chk(miss == !exp_hit, "R2", miss, !exp_hit);
    @(negedge clk);                                   // after k+2
    chk(!hit && !miss, "R2", hit | miss, 0);
    chk(done == !exp_hit, "R7", done, !exp_hit);
    if (wr) exp_mem[exp_addr] = s;
    @(negedge clk);                                   // after k+3
    if (st) begin
      if (exp_addr == DP - 1) begin exp_addr = 0; exp_wrap = 1'b1; end
      else exp_addr++;
    end
    chk(log_addr == AW'(exp_addr), "R5", log_addr, exp_addr);
    chk(wrapped == exp_wrap, "R6", wrapped, exp_wrap);
    chk(done == 1'b0, "R7", done, 0);
    @(negedge clk);                                   // after k+4
    chk(done == st, "R7", done, st);
    @(negedge clk);
    chk(done == 1'b0, "R7", done, 0);
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk);
    chk(rd_data == exp_mem[a], req, rd_data, exp_mem[a]);
  endtask

  task automatic quiet(input logic [DW-1:0] s, input string req);
    int a0;
    a0 = exp_addr;
    @(negedge clk); smp_valid = 1'b1; smp_data = s;
    @(negedge clk); smp_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(!hit && !miss && !done, req, {hit, miss, done}, 0);
      chk(log_addr == AW'(a0), req, log_addr, a0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!hit && !miss && !done, "R1", {hit, miss, done}, 0);
    chk(log_addr == '0, "R1", log_addr, 0);
    chk(wrapped == 1'b0, "R1", wrapped, 0);

    // vector table: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      set_thr(VEC[i][2*DW:DW+1]);
      log_one(VEC[i][DW:1], VEC[i][0]);
    end
    for (int i = 0; i < exp_addr; i++) rd_chk(i, "R4");

    // fill to wrap: R6
    set_thr(8'h00);
    while (!exp_wrap) log_one(8'hA0 + 8'(exp_addr), 1'b1);
    chk(log_addr == '0 && wrapped, "R6", log_addr, 0);
    rd_chk(DP - 1, "R4");

    // R8: load ignored without threshold power
    set_thr(8'h50);
    pwr_en[PW_THR] = 1'b0;
    set_thr(8'h00);
    pwr_en[PW_THR] = 1'b1;
    log_one(8'h20, 1'b0);
    log_one(8'h50, 1'b1);

    // R9: sample unit off, comparator off
    pwr_en[PW_SMP] = 1'b0; quiet(8'hFF, "R9"); pwr_en[PW_SMP] = 1'b1;
    pwr_en[PW_CMP] = 1'b0; quiet(8'hFF, "R9"); pwr_en[PW_CMP] = 1'b1;

    // R9: memory off, hit but no write, no step, no done
    pwr_en[PW_MEM] = 1'b0;
    log_one(8'h99, 1'b1);
    pwr_en[PW_MEM] = 1'b1;
    rd_chk(exp_addr, "R9");

    // R9: address unit off, write but no step
    pwr_en[PW_ADR] = 1'b0;
    log_one(8'h77, 1'b1);
    pwr_en[PW_ADR] = 1'b1;
    rd_chk(exp_addr, "R9");

    // R1: reset after activity
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(log_addr == '0, "R1", log_addr, 0);
    chk(wrapped == 1'b0, "R1", wrapped, 0);
    chk(!hit && !miss && !done, "R1", {hit, miss, done}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule